// File: doc/BRIEF.md
# Boot-Loaded Lockable Configuration Register

This block holds one 32-bit configuration word for a chip subsystem. Reset gives it a fixed hardware value. During the pre-boot window the boot sequencer pulses a load strobe and presents a word read from nonvolatile storage, together with three status flags: a read failure, a blank (erased) indication and an info-valid flag. The block copies the word only when it can be trusted, meaning no failure, not blank, and info-valid low. In every other case the reset value stays in place. Only the first strobe after reset counts. Whatever that strobe carries, it closes the load window.

After boot, software writes the register through a plain write port. A write takes effect only while a two-bit lock code reads unlocked. A write attempted under any other lock code is dropped, and a sticky violation flag is raised that only reset clears. Three multi-bit fields of the register are also brought out as separate outputs so that neighbouring logic can decode them directly: a 5-bit postscale, a 2-bit clock source and a 2-bit event select.

Top module: `cfg_boot_reg`

## Requirements
- R1: After reset, `cfg_value` is 0x840E4000 and `lock_viol` is 0.
- R2: On the first `boot_load` after reset, if `boot_fail`=0, `boot_blank`=0 and `boot_info_vld`=0, then `cfg_value` equals `boot_word` one clock later.
- R3: On the first `boot_load` after reset, if any of `boot_fail`, `boot_blank` or `boot_info_vld` is 1, then `cfg_value` keeps its current value.
- R4: When `wr_en`=1 and `lock_code`=2'b00, and no first boot load occurs in that cycle, `cfg_value` equals `wr_data` one clock later.
- R5: When `wr_en`=1 and `lock_code` is anything other than 2'b00, the write is ignored and `cfg_value` does not change.
- R6: A write attempted while `lock_code` is not 2'b00 sets `lock_viol` one clock later. The flag then stays at 1 until reset. A write with `lock_code`=2'b00 never sets it.
- R7: When the first `boot_load` after reset arrives in the same cycle as a software write, the boot load wins. The write is discarded whether or not the boot word is trusted.
- R8: A `boot_load` after the first one since reset changes nothing and does not block a software write in the same cycle. This holds even when the first strobe was untrusted.
- R9: `cfg_postscale` always equals `cfg_value[25:21]`, `cfg_clk_src` always equals `cfg_value[13:12]`, and `cfg_evt_sel` always equals `cfg_value[9:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_load | input | 1 | Pre-boot load strobe |
| boot_word | input | 32 | Word read from nonvolatile storage |
| boot_fail | input | 1 | The read of the word failed |
| boot_blank | input | 1 | The storage location is blank or erased |
| boot_info_vld | input | 1 | Info-valid flag; it must be 0 for the word to be trusted |
| lock_code | input | 2 | Lock code; 2'b00 means unlocked |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| cfg_value | output | 32 | Current register value |
| lock_viol | output | 1 | Sticky flag set by a write attempted while locked |
| cfg_postscale | output | 5 | Postscale field, bits 25:21 |
| cfg_clk_src | output | 2 | Clock source field, bits 13:12 |
| cfg_evt_sel | output | 2 | Event select field, bits 9:8 |

## Verification
The assertions check on every cycle the rules that a single clock step decides. A trusted first load copies the word. An untrusted first load, a locked write and a late strobe each leave the value alone. The violation flag and the window-closed state never fall without a reset. The field outputs follow their bit ranges. Two things only the bench scenarios can show. One is that a failed first strobe really does close the window for a later trusted one. The other is that a strobe colliding with a write ends in the right value across a full sequence of reset, boot and software access.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int unsigned CFG_W  = 32;
    localparam int unsigned LOCK_W = 2;

    localparam logic [LOCK_W-1:0] LOCK_OPEN = '0;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             used;
        logic             viol;
    } cfg_state_t;

endpackage

// File: rtl/cfg_boot_gate.sv
module cfg_boot_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_load,
    input  logic boot_fail,
    input  logic boot_blank,
    input  logic boot_info_vld,
    input  logic used_q,
    output logic first_hit,
    output logic take_word
);

    logic trusted;

    always_comb begin
        trusted   = !boot_fail && !boot_blank && !boot_info_vld;
        first_hit = boot_load && !used_q;
        take_word = first_hit && trusted;
    end

    // R8
    window_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q |=> used_q);

    // R8
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_hit |=> used_q);

endmodule

// File: rtl/cfg_write_gate.sv
module cfg_write_gate
    import cfgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LOCK_W-1:0] lock_code,
    input  logic              boot_first,
    output logic              wr_take,
    output logic              viol_hit
);

    logic unlocked;

    always_comb begin
        unlocked = (lock_code == LOCK_OPEN);
        wr_take  = wr_en && unlocked && !boot_first;
        viol_hit = wr_en && !unlocked;
    end

    // R7
    boot_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_first |-> !wr_take);

endmodule

// File: rtl/cfg_state_reg.sv
module cfg_state_reg
    import cfgreg_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VALUE = 32'h840E_4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_hit,
    input  logic             take_word,
    input  logic [CFG_W-1:0] boot_word,
    input  logic             wr_take,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             viol_hit,
    output cfg_state_t       st_q
);

    cfg_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (take_word) begin
            st_d.cfg = boot_word;
        end else if (wr_take) begin
            st_d.cfg = wr_data;
        end
        if (first_hit) begin
            st_d.used = 1'b1;
        end
        if (viol_hit) begin
            st_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= RESET_VALUE;
            st_q.used <= 1'b0;
            st_q.viol <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.viol |=> st_q.viol);

    // R6
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_hit |=> st_q.viol);

endmodule

// File: rtl/cfg_boot_reg.sv
module cfg_boot_reg
    import cfgreg_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VALUE = 32'h840E_4000,
    parameter int unsigned      PS_LSB      = 21,
    parameter int unsigned      PS_W        = 5,
    parameter int unsigned      SRC_LSB     = 12,
    parameter int unsigned      SRC_W       = 2,
    parameter int unsigned      EVT_LSB     = 8,
    parameter int unsigned      EVT_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_load,
    input  logic [CFG_W-1:0]  boot_word,
    input  logic              boot_fail,
    input  logic              boot_blank,
    input  logic              boot_info_vld,
    input  logic [LOCK_W-1:0] lock_code,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [CFG_W-1:0]  cfg_value,
    output logic              lock_viol,
    output logic [PS_W-1:0]   cfg_postscale,
    output logic [SRC_W-1:0]  cfg_clk_src,
    output logic [EVT_W-1:0]  cfg_evt_sel
);

    cfg_state_t st_q;
    logic       first_hit;
    logic       take_word;
    logic       wr_take;
    logic       viol_hit;

    cfg_boot_gate u_boot_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .boot_load     (boot_load),
        .boot_fail     (boot_fail),
        .boot_blank    (boot_blank),
        .boot_info_vld (boot_info_vld),
        .used_q        (st_q.used),
        .first_hit     (first_hit),
        .take_word     (take_word)
    );

    cfg_write_gate u_write_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .lock_code  (lock_code),
        .boot_first (first_hit),
        .wr_take    (wr_take),
        .viol_hit   (viol_hit)
    );

    cfg_state_reg #(
        .RESET_VALUE (RESET_VALUE)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .first_hit (first_hit),
        .take_word (take_word),
        .boot_word (boot_word),
        .wr_take   (wr_take),
        .wr_data   (wr_data),
        .viol_hit  (viol_hit),
        .st_q      (st_q)
    );

    always_comb begin
        cfg_value     = st_q.cfg;
        lock_viol     = st_q.viol;
        cfg_postscale = st_q.cfg[PS_LSB  +: PS_W];
        cfg_clk_src   = st_q.cfg[SRC_LSB +: SRC_W];
        cfg_evt_sel   = st_q.cfg[EVT_LSB +: EVT_W];
    end

    // R2
    trusted_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_load && !st_q.used && !boot_fail && !boot_blank && !boot_info_vld)
        |=> (cfg_value == $past(boot_word)));

    // R3
    untrusted_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_load && !st_q.used && (boot_fail || boot_blank || boot_info_vld))
        |=> $stable(cfg_value));

    // R5
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (lock_code != LOCK_OPEN) && !(boot_load && !st_q.used))
        |=> $stable(cfg_value));

    // R8
    late_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.used && !(wr_en && (lock_code == LOCK_OPEN)))
        |=> $stable(cfg_value));

    // R9
    field_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_postscale == cfg_value[25:21]) && (cfg_clk_src == cfg_value[13:12])
        && (cfg_evt_sel == cfg_value[9:8]));

endmodule

// File: tb/cfg_boot_reg_tb.sv
`timescale 1ns/1ps
module cfg_boot_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_load = 1'b0;
    logic [31:0] boot_word = '0;
    logic        boot_fail = 1'b0;
    logic        boot_blank = 1'b0;
    logic        boot_info_vld = 1'b0;
    logic [1:0]  lock_code = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cfg_value;
    logic        lock_viol;
    logic [4:0]  cfg_postscale;
    logic [1:0]  cfg_clk_src;
    logic [1:0]  cfg_evt_sel;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cfg_boot_reg u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .boot_load     (boot_load),
        .boot_word     (boot_word),
        .boot_fail     (boot_fail),
        .boot_blank    (boot_blank),
        .boot_info_vld (boot_info_vld),
        .lock_code     (lock_code),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .cfg_value     (cfg_value),
        .lock_viol     (lock_viol),
        .cfg_postscale (cfg_postscale),
        .cfg_clk_src   (cfg_clk_src),
        .cfg_evt_sel   (cfg_evt_sel)
    );

    typedef struct packed {
        logic        rst;
        logic        ld;
        logic        fail;
        logic        blank;
        logic        info;
        logic [31:0] word;
        logic [1:0]  lock;
        logic        we;
        logic [31:0] wdata;
        logic [31:0] exp_cfg;
        logic        exp_viol;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R2 trusted first load
        '{1'b1,1'b1,1'b0,1'b0,1'b0,32'hA5A5_1234,2'b00,1'b0,32'h0,         32'hA5A5_1234,1'b0,4'd2},
        // R8 second strobe ignored
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'hFFFF_0000,2'b00,1'b0,32'h0,         32'hA5A5_1234,1'b0,4'd8},
        // R4 unlocked write
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        2'b00,1'b1,32'h0000_BEEF, 32'h0000_BEEF,1'b0,4'd4},
        // R5 locked write dropped, flag raised
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        2'b01,1'b1,32'h1234_5678, 32'h0000_BEEF,1'b1,4'd5},
        // R6 flag stays after unlocked write
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        2'b00,1'b1,32'h1111_2222, 32'h1111_2222,1'b1,4'd6},
        // R3 failed read keeps reset value
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0000_0000,2'b00,1'b0,32'h0,         32'h840E_4000,1'b0,4'd3},
        // R3 blank read
        '{1'b1,1'b1,1'b0,1'b1,1'b0,32'h1234_0000,2'b00,1'b0,32'h0,         32'h840E_4000,1'b0,4'd3},
        // R3 info-valid set
        '{1'b1,1'b1,1'b0,1'b0,1'b1,32'h5555_5555,2'b00,1'b0,32'h0,         32'h840E_4000,1'b0,4'd3},
        // R7 trusted load beats write
        '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h0F0F_0F0F,2'b00,1'b1,32'h0000_DEAD, 32'h0F0F_0F0F,1'b0,4'd7},
        // R7 untrusted load still beats write
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0000_0000,2'b00,1'b1,32'h0000_0001, 32'h840E_4000,1'b0,4'd7},
        // R8 window closed by failed strobe
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0000_0005,2'b00,1'b0,32'h0,         32'h840E_4000,1'b0,4'd8},
        // R8 late strobe does not block write
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0000_0003,2'b00,1'b1,32'h0000_0077, 32'h0000_0077,1'b0,4'd8},
        // R5 lock code 2'b10
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        2'b10,1'b1,32'h0000_0000, 32'h0000_0077,1'b1,4'd5},
        // R6 lock code 2'b11, flag stays high
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        2'b11,1'b1,32'hFFFF_FFFF, 32'h0000_0077,1'b1,4'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_inputs();
        boot_load = 1'b0; boot_fail = 1'b0; boot_blank = 1'b0;
        boot_info_vld = 1'b0; wr_en = 1'b0; lock_code = 2'b00;
        boot_word = '0; wr_data = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 cfg", cfg_value, 32'h840E_4000);
        check("R1 viol", {31'b0, lock_viol}, 32'h0);
        // R9 fields of the reset value
        check("R9 ps", {27'b0, cfg_postscale}, 32'h0);
        check("R9 src", {30'b0, cfg_clk_src}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rst) do_reset();
            @(negedge clk);
            boot_load = VEC[i].ld; boot_fail = VEC[i].fail;
            boot_blank = VEC[i].blank; boot_info_vld = VEC[i].info;
            boot_word = VEC[i].word; lock_code = VEC[i].lock;
            wr_en = VEC[i].we; wr_data = VEC[i].wdata;
            @(negedge clk);
            check($sformatf("R%0d cfg vec%0d", VEC[i].req, i), cfg_value, VEC[i].exp_cfg);
            check($sformatf("R%0d viol vec%0d", VEC[i].req, i), {31'b0, lock_viol},
                  {31'b0, VEC[i].exp_viol});
            clear_inputs();
        end

        // R6 reset clears the sticky flag
        do_reset();
        check("R6 viol cleared", {31'b0, lock_viol}, 32'h0);

        // R9 field outputs after a trusted load
        @(negedge clk);
        boot_load = 1'b1; boot_word = 32'h02A0_2100;
        @(negedge clk);
        clear_inputs();
        check("R9 ps", {27'b0, cfg_postscale}, 32'd21);
        check("R9 src", {30'b0, cfg_clk_src}, 32'd2);
        check("R9 evt", {30'b0, cfg_evt_sel}, 32'd1);

        // R9 field outputs after an unlocked write
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h03E0_3300;
        @(negedge clk);
        clear_inputs();
        check("R4 cfg", cfg_value, 32'h03E0_3300);
        check("R9 ps", {27'b0, cfg_postscale}, 32'd31);
        check("R9 src", {30'b0, cfg_clk_src}, 32'd3);
        check("R9 evt", {30'b0, cfg_evt_sel}, 32'd3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule